// File: doc/BRIEF.md
# Fault Supervisor with Auto-Restart

This block sits beside the switching controller of an offline flyback converter and decides when the converter must stop. It receives single-bit flags from analog comparators: current-sense levels, feedback-sample levels, supply levels and temperature. It also receives timing strobes: a line zero-cross pulse, a switching-cycle strobe, a first-switching window and a free-running time tick. Each fault is qualified by its own rule. Some fault conditions stop the gate drive at once. Others must persist for a count of switching cycles, for a number of consecutive line half-cycles, or for an unbroken stretch of time.

The first fault to qualify is recorded as a 3-bit code and starts a timed restart sequence. The gate drive stops. The bias request then holds the supply inside a 17 V to 19 V band for a hold period, which defaults to 3 s at a 1 µs tick. After the hold period, the bias request is released so that the supply falls to its lockout level. A one-cycle reset request then clears the recorded fault. The block then waits for the supply to reach its turn-on level before switching resumes.

Top module: `fault_supervisor`

## Requirements
- R1: While running, `isense_trip` (current sense above 1.8 V) forces `drive_en` low in the same cycle, and fault code 1 is recorded at the next clock edge.
- R2: While running, an overload trip occurs at the zero-cross pulse that closes the OVERLOAD_ZC-th consecutive interval containing an `isense_limit` event. An interval without such an event restarts the count. The recorded code is 6. An `isense_limit` in the same cycle as `zc` belongs to the interval that this `zc` closes.
- R3: While running, the output-short fault trips on the tick that completes SHORT_TICKS ticks of an unbroken low-sample condition, and code 5 is recorded. The condition is set by `fb_low` (below 0.7 V). It persists while neither `fb_low` nor `fb_high` is asserted. It ends only on `fb_high` (above 0.9 V), which clears the tick count.
- R4: While running, an over-voltage trip from the feedback sample occurs on the FB_OVER_CYCLES-th consecutive `sw_strobe` at which `fb_over` is high, and code 3 is recorded. A strobe with `fb_over` low restarts the count.
- R5: While running, `sup_over` (supply above 25 V) held for SUPPLY_OV_TICKS consecutive ticks trips with code 4. Dropping `sup_over` restarts the count.
- R6: While running, if `first_sw` falls and `isense_min` (above 75 mV) was not seen in any cycle of that window, the drive stops in the falling cycle and code 2 is recorded.
- R7: `temp_hot` (above 150 °C) trips with code 7. The over-temperature condition persists, and blocks every later run, until `temp_cool` (below 120 °C) is seen.
- R8: When several faults qualify in the same cycle, the lowest code wins. The code is then held, with later faults ignored, until the reset request. It reads 0 in the cycle after `rst_req`.
- R9: After a trip, `drive_en` stays low. During the hold period, `bias_req` rises on `sup_below17` and falls on `sup_above19`, and keeps its value when neither flag is asserted.
- R10: After HOLD_TICKS ticks of hold, `bias_req` is 0 until `sup_uvlo` is seen. `rst_req` then pulses for one cycle. The block then asserts `bias_req` and waits, and `drive_en` goes high in the cycle after `sup_on` is sampled.
- R11: After reset, `drive_en`, `rst_req` and `fault_code` are 0 and `bias_req` is 1.
- R12: All cycle, interval and time counts are cleared whenever the block is not running, so no partial count carries across a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time base strobe, one pulse per time unit |
| sw_strobe | input | 1 | One pulse per switching cycle |
| zc | input | 1 | Line zero-cross pulse |
| first_sw | input | 1 | High during the on-time of the first switching cycle |
| isense_trip | input | 1 | Current sense above 1.8 V |
| isense_limit | input | 1 | Current sense reached the 1.2 V cycle limit |
| isense_min | input | 1 | Current sense above 75 mV |
| fb_low | input | 1 | Feedback sample below 0.7 V |
| fb_high | input | 1 | Feedback sample above 0.9 V |
| fb_over | input | 1 | Feedback sample above the over-voltage threshold |
| sup_over | input | 1 | Supply above 25 V |
| temp_hot | input | 1 | Junction above 150 °C |
| temp_cool | input | 1 | Junction below 120 °C |
| sup_on | input | 1 | Supply at or above the 16 V turn-on level |
| sup_below17 | input | 1 | Supply below 17 V |
| sup_above19 | input | 1 | Supply above 19 V |
| sup_uvlo | input | 1 | Supply below the 7.75 V lockout level |
| drive_en | output | 1 | Gate drive permitted |
| bias_req | output | 1 | Request to the high-voltage bias source |
| rst_req | output | 1 | One-cycle chip reset request |
| fault_code | output | 3 | Recorded fault, 0 when none |

## Verification
The hardest situations to reach are the ones where a count must survive or be lost across a boundary. One is the output-short filter while the sample sits between its two thresholds. Another is a partial over-voltage streak that is cut short by an unrelated trip and must not carry into the next run. The stimulus builds a partial streak, forces a different fault, and runs a full hold, drain and reset sequence. It then shows that a single further qualifying cycle does not trip. For the short filter, the stimulus lets ticks accumulate across the mid band, clears the count with one high-sample cycle, and then places the trip one tick after a check that the drive is still on. The persistent over-temperature case is reached by restarting while the hot condition is still held, which must trip again on the first run cycle.

// File: rtl/fsup_pkg.sv
`timescale 1ns/1ps
package fsup_pkg;

    typedef enum logic [2:0] {
        FC_NONE        = 3'd0,
        FC_OVERCURRENT = 3'd1,
        FC_RSENSE      = 3'd2,
        FC_FB_OVER     = 3'd3,
        FC_SUPPLY_OVER = 3'd4,
        FC_OUT_SHORT   = 3'd5,
        FC_OVERLOAD    = 3'd6,
        FC_THERMAL     = 3'd7
    } fault_code_e;

    typedef enum logic [2:0] {
        ST_WAKE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_HOLD  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_RESET = 3'd4
    } phase_e;

    typedef struct packed {
        logic thermal;
        logic overload;
        logic out_short;
        logic supply_over;
        logic fb_over;
        logic rsense;
        logic overcurrent;
    } fault_vec_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // lowest code wins when several faults qualify together
    function automatic fault_code_e pick_fault(input fault_vec_t v);
        if (v.overcurrent)      return FC_OVERCURRENT;
        else if (v.rsense)      return FC_RSENSE;
        else if (v.fb_over)     return FC_FB_OVER;
        else if (v.supply_over) return FC_SUPPLY_OVER;
        else if (v.out_short)   return FC_OUT_SHORT;
        else if (v.overload)    return FC_OVERLOAD;
        else if (v.thermal)     return FC_THERMAL;
        else                    return FC_NONE;
    endfunction

endpackage

// File: rtl/fsup_streak.sv
`timescale 1ns/1ps
// Counts consecutive strobes with the event present; hit on the N-th.
module fsup_streak
    import fsup_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic strobe,
    input  logic ev,
    output logic hit
);
    localparam int unsigned CW = cnt_width(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);
    localparam logic [CW-1:0] TOP  = CW'(N);

    logic [CW-1:0] cnt;

    assign hit = ~clr & strobe & ev & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (strobe) begin
            if (!ev)
                cnt <= '0;
            else if (cnt != TOP)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsup_dwell.sv
`timescale 1ns/1ps
// Counts ticks while a condition holds without a break; hit on the N-th.
// HYST=1: condition set by set_in, kept until rel_in. HYST=0: set_in & ~rel_in.
module fsup_dwell
    import fsup_pkg::*;
#(
    parameter int unsigned N    = 10,
    parameter bit          HYST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic set_in,
    input  logic rel_in,
    output logic hit
);
    localparam int unsigned CW = cnt_width(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);
    localparam logic [CW-1:0] TOP  = CW'(N);

    logic          cond;
    logic [CW-1:0] cnt;

    generate
        if (HYST) begin : g_hyst
            logic held;
            assign cond = set_in | (held & ~rel_in);
            always_ff @(posedge clk) begin
                if (rst || clr)
                    held <= 1'b0;
                else
                    held <= cond;
            end
        end else begin : g_plain
            assign cond = set_in & ~rel_in;
        end
    endgenerate

    assign hit = ~clr & tick & cond & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !cond)
            cnt <= '0;
        else if (tick && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fsup_restart.sv
`timescale 1ns/1ps
// Run / hold / drain / reset sequencing with supply band regulation.
module fsup_restart
    import fsup_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 3000000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   trip,
    input  logic   sup_on,
    input  logic   sup_below17,
    input  logic   sup_above19,
    input  logic   sup_uvlo,
    output phase_e phase,
    output logic   bias_req,
    output logic   rst_req
);
    localparam int unsigned TW = cnt_width(HOLD_TICKS);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_TICKS - 1);

    phase_e        ph;
    logic [TW-1:0] tmr;
    logic          band;
    logic          band_nx;

    assign band_nx = sup_below17 | (band & ~sup_above19);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= ST_WAKE;
            tmr  <= '0;
            band <= 1'b0;
        end else begin
            case (ph)
                ST_WAKE: begin
                    if (sup_on)
                        ph <= ST_RUN;
                end
                ST_RUN: begin
                    tmr  <= '0;
                    band <= 1'b0;
                    if (trip)
                        ph <= ST_HOLD;
                end
                ST_HOLD: begin
                    band <= band_nx;
                    if (tick) begin
                        if (tmr == HOLD_LAST) begin
                            tmr <= '0;
                            ph  <= ST_DRAIN;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (sup_uvlo)
                        ph <= ST_RESET;
                end
                ST_RESET: ph <= ST_WAKE;
                default:  ph <= ST_WAKE;
            endcase
        end
    end

    always_comb begin
        case (ph)
            ST_WAKE: bias_req = 1'b1;
            ST_HOLD: bias_req = band_nx;
            default: bias_req = 1'b0;
        endcase
    end

    assign rst_req = (ph == ST_RESET);
    assign phase   = ph;
endmodule

// File: rtl/fault_supervisor.sv
`timescale 1ns/1ps
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned OVERLOAD_ZC      = 60,
    parameter int unsigned FB_OVER_CYCLES   = 4,
    parameter int unsigned SHORT_TICKS      = 35000,
    parameter int unsigned SUPPLY_OV_TICKS  = 10,
    parameter int unsigned HOLD_TICKS       = 3000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sw_strobe,
    input  logic       zc,
    input  logic       first_sw,
    input  logic       isense_trip,
    input  logic       isense_limit,
    input  logic       isense_min,
    input  logic       fb_low,
    input  logic       fb_high,
    input  logic       fb_over,
    input  logic       sup_over,
    input  logic       temp_hot,
    input  logic       temp_cool,
    input  logic       sup_on,
    input  logic       sup_below17,
    input  logic       sup_above19,
    input  logic       sup_uvlo,
    output logic       drive_en,
    output logic       bias_req,
    output logic       rst_req,
    output logic [2:0] fault_code
);
    phase_e      phase;
    logic        run;
    logic        clr;
    fault_vec_t  qual;
    logic        any_qual;
    logic        trip;
    fault_code_e code_q;

    assign run = (phase == ST_RUN);
    assign clr = ~run;

    // overload: current-limit event inside each zero-cross interval
    logic ovl_seen;
    logic ovl_ev;
    logic hit_ovl;
    assign ovl_ev = ovl_seen | isense_limit;

    always_ff @(posedge clk) begin
        if (rst || clr || zc)
            ovl_seen <= 1'b0;
        else
            ovl_seen <= ovl_ev;
    end

    fsup_streak #(.N(OVERLOAD_ZC)) u_overload (
        .clk(clk), .rst(rst), .clr(clr),
        .strobe(zc), .ev(ovl_ev), .hit(hit_ovl)
    );

    // feedback over-voltage: consecutive switching cycles
    logic hit_fbov;
    fsup_streak #(.N(FB_OVER_CYCLES)) u_fb_over (
        .clk(clk), .rst(rst), .clr(clr),
        .strobe(sw_strobe), .ev(fb_over), .hit(hit_fbov)
    );

    // output short: continuous time with two-level release
    logic hit_short;
    fsup_dwell #(.N(SHORT_TICKS), .HYST(1'b1)) u_short (
        .clk(clk), .rst(rst), .clr(clr), .tick(tick),
        .set_in(fb_low), .rel_in(fb_high), .hit(hit_short)
    );

    // supply over-voltage: continuous time filter
    logic hit_supov;
    fsup_dwell #(.N(SUPPLY_OV_TICKS), .HYST(1'b0)) u_supply_ov (
        .clk(clk), .rst(rst), .clr(clr), .tick(tick),
        .set_in(sup_over), .rel_in(1'b0), .hit(hit_supov)
    );

    // sense-resistor short: no minimum current seen in the first on-time
    logic fs_d;
    logic fs_seen;
    logic hit_rsense;
    assign hit_rsense = run & fs_d & ~first_sw & ~fs_seen;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fs_d    <= 1'b0;
            fs_seen <= 1'b0;
        end else begin
            fs_d <= first_sw;
            if (first_sw && !fs_d)
                fs_seen <= isense_min;
            else if (first_sw)
                fs_seen <= fs_seen | isense_min;
        end
    end

    // over-temperature with release hysteresis; tracks temperature always
    logic hot_held;
    logic hot_now;
    assign hot_now = temp_hot | (hot_held & ~temp_cool);

    always_ff @(posedge clk) begin
        if (rst)
            hot_held <= 1'b0;
        else
            hot_held <= hot_now;
    end

    always_comb begin
        qual             = '0;
        qual.overcurrent = isense_trip;
        qual.rsense      = hit_rsense;
        qual.fb_over     = hit_fbov;
        qual.supply_over = hit_supov;
        qual.out_short   = hit_short;
        qual.overload    = hit_ovl;
        qual.thermal     = hot_now;
    end

    assign any_qual = |qual;
    assign trip     = run & any_qual;
    assign drive_en = run & ~any_qual;

    always_ff @(posedge clk) begin
        if (rst || phase == ST_RESET)
            code_q <= FC_NONE;
        else if (trip)
            code_q <= pick_fault(qual);
    end

    assign fault_code = code_q;

    fsup_restart #(.HOLD_TICKS(HOLD_TICKS)) u_restart (
        .clk(clk), .rst(rst), .tick(tick), .trip(trip),
        .sup_on(sup_on), .sup_below17(sup_below17),
        .sup_above19(sup_above19), .sup_uvlo(sup_uvlo),
        .phase(phase), .bias_req(bias_req), .rst_req(rst_req)
    );
endmodule

// File: rtl/fsup_checker.sv
`timescale 1ns/1ps
module fsup_checker (
    input logic       clk,
    input logic       rst,
    input logic       isense_trip,
    input logic       sup_on,
    input logic       sup_uvlo,
    input logic       drive_en,
    input logic       bias_req,
    input logic       rst_req,
    input logic [2:0] fault_code
);
    AST_TRIP_KILLS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        isense_trip |-> !drive_en); // R1
    AST_CODE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0) |-> !drive_en); // R9
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 3'd0 && !rst_req) |=> (fault_code == $past(fault_code))); // R8
    AST_CODE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (fault_code == 3'd0)); // R8
    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R10
    AST_RESET_AFTER_UVLO: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(sup_uvlo)); // R10
    AST_NO_BIAS_WHILE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> !bias_req); // R10
    AST_START_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> $past(sup_on)); // R10
endmodule

bind fault_supervisor fsup_checker u_chk (
    .clk(clk), .rst(rst), .isense_trip(isense_trip), .sup_on(sup_on),
    .sup_uvlo(sup_uvlo), .drive_en(drive_en), .bias_req(bias_req),
    .rst_req(rst_req), .fault_code(fault_code)
);

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;
    localparam int OLZ  = 60;
    localparam int FBC  = 4;
    localparam int SHT  = 350;
    localparam int SOV  = 10;
    localparam int HOLD = 200;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic tick = 0, sw_strobe = 0, zc = 0, first_sw = 0;
    logic isense_trip = 0, isense_limit = 0, isense_min = 0;
    logic fb_low = 0, fb_high = 0, fb_over = 0, sup_over = 0;
    logic temp_hot = 0, temp_cool = 0;
    logic sup_on = 0, sup_below17 = 0, sup_above19 = 0, sup_uvlo = 0;
    logic drive_en, bias_req, rst_req;
    logic [2:0] fault_code;

    fault_supervisor #(
        .OVERLOAD_ZC(OLZ), .FB_OVER_CYCLES(FBC), .SHORT_TICKS(SHT),
        .SUPPLY_OV_TICKS(SOV), .HOLD_TICKS(HOLD)
    ) uut (
        .clk(clk), .rst(rst), .tick(tick), .sw_strobe(sw_strobe), .zc(zc),
        .first_sw(first_sw), .isense_trip(isense_trip), .isense_limit(isense_limit),
        .isense_min(isense_min), .fb_low(fb_low), .fb_high(fb_high), .fb_over(fb_over),
        .sup_over(sup_over), .temp_hot(temp_hot), .temp_cool(temp_cool),
        .sup_on(sup_on), .sup_below17(sup_below17), .sup_above19(sup_above19),
        .sup_uvlo(sup_uvlo), .drive_en(drive_en), .bias_req(bias_req),
        .rst_req(rst_req), .fault_code(fault_code)
    );

    int vectors = 0;
    int miscompares = 0;

    // behavioural reference: phase 0 wait, 1 run, 2 hold, 3 drain, 4 reset
    int m_ph, m_ovl_n, m_fb_n, m_sh_n, m_sov_n, m_hold_n, m_code;
    bit m_ovl_seen, m_sh_on, m_fs_d, m_fs_seen, m_hot, m_band;
    bit e_run, e_any, e_ovl_ev, e_sh_cond, e_hot, e_band, e_gate, e_bias;
    int e_code;

    task automatic m_eval();
        bit f_oc, f_rs, f_fb, f_sov, f_sh, f_ol;
        e_run     = (m_ph == 1);
        e_ovl_ev  = m_ovl_seen | isense_limit;
        e_sh_cond = fb_low | (m_sh_on & !fb_high);
        e_hot     = temp_hot | (m_hot & !temp_cool);
        f_oc  = e_run && isense_trip;
        f_rs  = e_run && m_fs_d && !first_sw && !m_fs_seen;
        f_fb  = e_run && sw_strobe && fb_over && (m_fb_n == FBC - 1);
        f_sov = e_run && tick && sup_over && (m_sov_n == SOV - 1);
        f_sh  = e_run && tick && e_sh_cond && (m_sh_n == SHT - 1);
        f_ol  = e_run && zc && e_ovl_ev && (m_ovl_n == OLZ - 1);
        e_code = f_oc ? 1 : f_rs ? 2 : f_fb ? 3 : f_sov ? 4 : f_sh ? 5 : f_ol ? 6 :
                 (e_run && e_hot) ? 7 : 0;
        e_any  = (e_code != 0);
        e_gate = e_run && !e_any;
        e_band = sup_below17 | (m_band & !sup_above19);
        e_bias = (m_ph == 0) ? 1'b1 : (m_ph == 2) ? e_band : 1'b0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_ovl_n = 0; m_fb_n = 0; m_sh_n = 0; m_sov_n = 0;
            m_hold_n = 0; m_code = 0; m_ovl_seen = 0; m_sh_on = 0;
            m_fs_d = 0; m_fs_seen = 0; m_hot = 0; m_band = 0;
        end else begin
            m_eval();
            if (!e_run) begin
                m_ovl_n = 0; m_fb_n = 0; m_sh_n = 0; m_sov_n = 0;
                m_ovl_seen = 0; m_sh_on = 0; m_fs_d = 0; m_fs_seen = 0;
            end else begin
                if (zc) begin
                    m_ovl_n = e_ovl_ev ? m_ovl_n + 1 : 0;
                    m_ovl_seen = 0;
                end else m_ovl_seen = e_ovl_ev;
                if (sw_strobe) m_fb_n = fb_over ? m_fb_n + 1 : 0;
                m_sh_on = e_sh_cond;
                if (!e_sh_cond) m_sh_n = 0; else if (tick) m_sh_n++;
                if (!sup_over) m_sov_n = 0; else if (tick) m_sov_n++;
                if (first_sw && !m_fs_d) m_fs_seen = isense_min;
                else if (first_sw) m_fs_seen = m_fs_seen | isense_min;
                m_fs_d = first_sw;
            end
            m_hot = e_hot;
            if (m_ph == 4) m_code = 0;
            else if (e_any) m_code = e_code;
            case (m_ph)
                0: if (sup_on) m_ph = 1;
                1: begin m_band = 0; m_hold_n = 0; if (e_any) m_ph = 2; end
                2: begin
                    m_band = e_band;
                    if (tick) begin
                        if (m_hold_n == HOLD - 1) begin m_hold_n = 0; m_ph = 3; end
                        else m_hold_n++;
                    end
                end
                3: if (sup_uvlo) m_ph = 4;
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            m_eval();
            chk("R9 drive_en per cycle", int'(drive_en), int'(e_gate));
            chk("R9 bias_req per cycle", int'(bias_req), int'(e_bias));
            chk("R10 rst_req per cycle", int'(rst_req), int'(m_ph == 4));
            chk("R8 fault_code per cycle", int'(fault_code), m_code);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic start_up();
        sup_on = 1; step(); sup_on = 0; step();
    endtask

    task automatic recycle();
        tick = 1;
        repeat (HOLD + 5) step();
        chk("R10 bias off after hold", int'(bias_req), 0);
        sup_below17 = 1; step();
        chk("R10 band ignored in drain", int'(bias_req), 0);
        sup_below17 = 0; sup_uvlo = 1; step();
        chk("R10 reset request", int'(rst_req), 1);
        sup_uvlo = 0; step();
        chk("R10 reset pulse ends", int'(rst_req), 0);
        chk("R8 code cleared after reset", int'(fault_code), 0);
        chk("R10 bias on while waiting", int'(bias_req), 1);
        tick = 0;
    endtask

    task automatic zc_interval(input bit with_limit);
        isense_limit = with_limit; step(); isense_limit = 0; step();
        zc = 1; step(); zc = 0; step();
    endtask

    task automatic sw_cycle(input bit over);
        fb_over = over; sw_strobe = 1; step();
        sw_strobe = 0; fb_over = 0; step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog expired: actual 0 expected 1 (completion)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 0; step();
        chk("R11 drive after reset", int'(drive_en), 0);
        chk("R11 bias after reset", int'(bias_req), 1);
        chk("R11 rst_req after reset", int'(rst_req), 0);
        chk("R11 code after reset", int'(fault_code), 0);

        // over-current and band regulation
        start_up();
        chk("R10 drive after turn-on", int'(drive_en), 1);
        isense_trip = 1; #1;
        chk("R1 drive drops same cycle", int'(drive_en), 0);
        step(); isense_trip = 0;
        chk("R1 code over-current", int'(fault_code), 1);
        sup_below17 = 1; step();
        chk("R9 bias rises below 17", int'(bias_req), 1);
        sup_below17 = 0; step();
        chk("R9 bias held in band", int'(bias_req), 1);
        sup_above19 = 1; step();
        chk("R9 bias falls above 19", int'(bias_req), 0);
        sup_above19 = 0; step();
        chk("R9 bias stays off in band", int'(bias_req), 0);
        sup_over = 1; tick = 1; repeat (SOV + 2) step(); sup_over = 0; tick = 0;
        chk("R8 later fault ignored", int'(fault_code), 1);
        recycle();

        // priority
        start_up();
        isense_trip = 1; temp_hot = 1; step();
        isense_trip = 0; temp_hot = 0; temp_cool = 1; step(); temp_cool = 0;
        chk("R8 lowest code wins", int'(fault_code), 1);
        recycle();

        // overload
        start_up();
        repeat (OLZ - 1) zc_interval(1);
        chk("R2 no trip before count", int'(drive_en), 1);
        zc_interval(0);
        repeat (OLZ - 1) zc_interval(1);
        chk("R2 quiet interval restarted count", int'(drive_en), 1);
        zc_interval(1);
        chk("R2 overload code", int'(fault_code), 6);
        recycle();

        // feedback over-voltage streak and clearing across restart
        start_up();
        repeat (FBC - 1) sw_cycle(1);
        sw_cycle(0);
        repeat (FBC - 1) sw_cycle(1);
        chk("R4 broken streak no trip", int'(drive_en), 1);
        isense_trip = 1; step(); isense_trip = 0;
        recycle();
        start_up();
        sw_cycle(1);
        chk("R12 streak not carried over restart", int'(drive_en), 1);
        repeat (FBC - 1) sw_cycle(1);
        chk("R4 over-voltage code", int'(fault_code), 3);
        recycle();

        // output short with hysteresis
        start_up();
        tick = 1;
        fb_low = 1; repeat (200) step();
        fb_low = 0; repeat (100) step();
        chk("R3 mid band no trip yet", int'(drive_en), 1);
        fb_high = 1; step(); fb_high = 0;
        fb_low = 1; repeat (SHT - 2) step();
        chk("R3 high sample cleared count", int'(drive_en), 1);
        step();
        chk("R3 trip on final tick", int'(drive_en), 0);
        step(); fb_low = 0;
        chk("R3 short code", int'(fault_code), 5);
        recycle();

        // supply over-voltage filter
        start_up();
        tick = 1;
        sup_over = 1; repeat (SOV - 2) step();
        sup_over = 0; step();
        sup_over = 1; repeat (SOV - 2) step();
        chk("R5 break restarted filter", int'(drive_en), 1);
        step();
        chk("R5 trip on final tick", int'(drive_en), 0);
        step(); sup_over = 0;
        chk("R5 supply code", int'(fault_code), 4);
        recycle();

        // sense-resistor short
        start_up();
        first_sw = 1; step(); isense_min = 1; step(); isense_min = 0; step();
        first_sw = 0; step();
        chk("R6 current seen no trip", int'(drive_en), 1);
        first_sw = 1; repeat (3) step();
        first_sw = 0; #1;
        chk("R6 drive stops at window end", int'(drive_en), 0);
        step();
        chk("R6 rsense code", int'(fault_code), 2);
        recycle();

        // over-temperature persistence
        start_up();
        temp_hot = 1; step(); temp_hot = 0; step();
        chk("R7 thermal code", int'(fault_code), 7);
        recycle();
        start_up();
        chk("R7 still hot blocks run", int'(drive_en), 0);
        step();
        chk("R7 thermal code again", int'(fault_code), 7);
        temp_cool = 1; step(); temp_cool = 0;
        recycle();
        start_up();
        chk("R7 runs after cooling", int'(drive_en), 1);
        step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule